// File: doc/BRIEF.md
# Unlock-Sequenced Flash Command Decoder

This block sits between a byte-wide host write port and the program/erase engine of a parallel NOR-style flash. Each host write arrives as a one-cycle strobe with an 18-bit address and an 8-bit data byte. The decoder looks for a two-write unlock key, then a command byte, and then any further writes that command needs. When a sequence is complete, it issues one registered pulse to the engine. The pulse carries an operation code and, where the operation needs them, the captured address and data.

The decoder also keeps the current read mode: array, autoselect or status. The read path outside the block uses it to choose what the array port returns. The engine reports whether it is programming, erasing or holding an erase in suspend, and the decoder uses these flags to decide which writes it accepts. An illegal sequence drops the decoder back to read-array without issuing a pulse. A low-supply lockout input does the same at any time.

Top module: `flash_cmd_decoder`

## Requirements
- R1: The unlock key is data AAh at address 555h, followed by data 55h at address AAAh. Only the low 12 address bits are compared; bits 17..12 are ignored.
- R2: Data 90h written to address 555h right after the unlock key pulses op code 1 (autoselect) and sets read mode 1 (autoselect).
- R3: Data A0h written to address 555h right after the unlock key arms program. The next write, at any address, pulses op code 2 (program) with that write's address and data, and sets read mode 2 (status).
- R4: Data 80h at 555h after the unlock key, then a second unlock key, then data 30h pulses op code 3 (block erase) with the address of that last write, and sets read mode 2.
- R5: The same six-write erase prefix ending in data 10h at address 555h pulses op code 4 (chip erase) and sets read mode 2.
- R6: Data F0h written alone, or written as the first or third write after an unlock key, pulses op code 0 (read reset) and sets read mode 0 (array).
- R7: While erase is busy, only two writes are accepted. B0h at any address pulses op code 5 (suspend) and sets read mode 0. F0h pulses op code 0. Every other write leaves the state and the outputs unchanged.
- R8: While the erase is suspended, 30h written alone pulses op code 6 (resume) and sets read mode 2, and the unlock-plus-A0h program sequence still works. Autoselect, erase setup and read reset are all treated as illegal.
- R9: Any write that does not fit the current step of a sequence returns the decoder to idle and sets read mode 0, with no pulse. This includes 30h or B0h written alone when no erase is active.
- R10: Reset, or lockout_i being high at a clock edge, clears any partial sequence and sets read mode 0, with no pulse on that cycle.
- R11: While prog_busy_i is high, writes are ignored: no pulse, and the sequence step and read mode are kept.
- R12: op_valid_o is high for exactly the one cycle after the accepting write. op_code_o, op_addr_o and op_data_o are only meaningful while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lockout_i | input | 1 | Low-supply lockout; forces read-array |
| wr_i | input | 1 | One-cycle host write strobe |
| addr_i | input | 18 | Write address |
| data_i | input | 8 | Write data |
| erase_busy_i | input | 1 | Engine is erasing |
| erase_susp_i | input | 1 | Engine holds a suspended erase |
| prog_busy_i | input | 1 | Engine is programming |
| op_valid_o | output | 1 | One-cycle operation pulse |
| op_code_o | output | 3 | Operation code (0 read reset, 1 autoselect, 2 program, 3 block erase, 4 chip erase, 5 suspend, 6 resume) |
| op_addr_o | output | 18 | Address captured with the pulse |
| op_data_o | output | 8 | Data captured with the pulse |
| read_mode_o | output | 2 | Read mode (0 array, 1 autoselect, 2 status) |

## Verification
The bench builds the decoder with its default parameters: an 18-bit address, a 12-bit key compare, and key addresses 555h and AAAh. Because the address is wider than the compare, the bench can write keys with nonzero upper address bits and show that those bits are ignored. It can also capture full 18-bit program and erase targets on the pulse. The engine flags are driven as plain inputs, so every gating case is reachable directly from the stimulus table: busy, suspended, and programming during a half-finished sequence.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    OP_READ    = 3'd0,
    OP_AUTOSEL = 3'd1,
    OP_PROG    = 3'd2,
    OP_BERASE  = 3'd3,
    OP_CERASE  = 3'd4,
    OP_SUSP    = 3'd5,
    OP_RESUME  = 3'd6
  } op_e;

  typedef enum logic [1:0] {
    RM_ARRAY   = 2'd0,
    RM_AUTOSEL = 2'd1,
    RM_STATUS  = 2'd2
  } rmode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_K1, S_K2, S_PGM, S_ESET, S_EK1, S_EK2
  } seq_e;

  localparam logic [7:0] KEY1_D   = 8'hAA;
  localparam logic [7:0] KEY2_D   = 8'h55;
  localparam logic [7:0] C_RESET  = 8'hF0;
  localparam logic [7:0] C_ASEL   = 8'h90;
  localparam logic [7:0] C_PROG   = 8'hA0;
  localparam logic [7:0] C_ESETUP = 8'h80;
  localparam logic [7:0] C_BLK    = 8'h30;
  localparam logic [7:0] C_CHIP   = 8'h10;
  localparam logic [7:0] C_SUSP   = 8'hB0;
  localparam logic [7:0] C_RESUME = 8'h30;
endpackage

// File: rtl/flash_wr_classify.sv
module flash_wr_classify
  import flash_cmd_pkg::*;
#(
  parameter int CMP_W = 12,
  parameter int DATA_W = 8,
  parameter logic [CMP_W-1:0] KEY1_A = 12'h555,
  parameter logic [CMP_W-1:0] KEY2_A = 12'hAAA
) (
  input  logic [CMP_W-1:0]  addr_lo_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              key1_o,
  output logic              key2_o,
  output logic              at_cmd_o
);
  assign at_cmd_o = (addr_lo_i == KEY1_A);
  assign key1_o   = at_cmd_o && (data_i == KEY1_D);
  assign key2_o   = (addr_lo_i == KEY2_A) && (data_i == KEY2_D);
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lockout_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              key1_i,
  input  logic              key2_i,
  input  logic              at_cmd_i,
  input  logic              erase_busy_i,
  input  logic              erase_susp_i,
  input  logic              prog_busy_i,
  output logic              op_valid_o,
  output op_e               op_code_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output rmode_e            read_mode_o
);
  seq_e   state_q, state_d;
  rmode_e mode_d;
  op_e    code_d;
  logic   fire_d;

  always_comb begin
    state_d = state_q;
    mode_d  = read_mode_o;
    code_d  = OP_READ;
    fire_d  = 1'b0;
    if (wr_i && !prog_busy_i) begin
      if (erase_busy_i) begin
        if (data_i == C_RESET) begin
          fire_d = 1'b1; code_d = OP_READ; mode_d = RM_ARRAY; state_d = S_IDLE;
        end else if (data_i == C_SUSP) begin
          fire_d = 1'b1; code_d = OP_SUSP; mode_d = RM_ARRAY; state_d = S_IDLE;
        end
      end else begin
        // default for every unmatched write: abort to read-array
        state_d = S_IDLE;
        mode_d  = RM_ARRAY;
        unique case (state_q)
          S_IDLE: begin
            if (key1_i) begin
              state_d = S_K1; mode_d = read_mode_o;
            end else if (erase_susp_i && data_i == C_RESUME) begin
              fire_d = 1'b1; code_d = OP_RESUME; mode_d = RM_STATUS;
            end else if (!erase_susp_i && data_i == C_RESET) begin
              fire_d = 1'b1; code_d = OP_READ;
            end
          end
          S_K1: begin
            if (key2_i) begin
              state_d = S_K2; mode_d = read_mode_o;
            end else if (!erase_susp_i && data_i == C_RESET) begin
              fire_d = 1'b1; code_d = OP_READ;
            end
          end
          S_K2: begin
            if (!erase_susp_i && data_i == C_RESET) begin
              fire_d = 1'b1; code_d = OP_READ;
            end else if (at_cmd_i && data_i == C_PROG) begin
              state_d = S_PGM; mode_d = read_mode_o;
            end else if (at_cmd_i && !erase_susp_i && data_i == C_ASEL) begin
              fire_d = 1'b1; code_d = OP_AUTOSEL; mode_d = RM_AUTOSEL;
            end else if (at_cmd_i && !erase_susp_i && data_i == C_ESETUP) begin
              state_d = S_ESET; mode_d = read_mode_o;
            end
          end
          S_PGM: begin
            fire_d = 1'b1; code_d = OP_PROG; mode_d = RM_STATUS;
          end
          S_ESET: if (key1_i) begin
            state_d = S_EK1; mode_d = read_mode_o;
          end
          S_EK1: if (key2_i) begin
            state_d = S_EK2; mode_d = read_mode_o;
          end
          S_EK2: begin
            if (data_i == C_BLK) begin
              fire_d = 1'b1; code_d = OP_BERASE; mode_d = RM_STATUS;
            end else if (at_cmd_i && data_i == C_CHIP) begin
              fire_d = 1'b1; code_d = OP_CERASE; mode_d = RM_STATUS;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      read_mode_o <= RM_ARRAY;
      op_valid_o  <= 1'b0;
      op_code_o   <= OP_READ;
      op_addr_o   <= '0;
      op_data_o   <= '0;
    end else if (lockout_i) begin
      state_q     <= S_IDLE;
      read_mode_o <= RM_ARRAY;
      op_valid_o  <= 1'b0;
    end else begin
      state_q     <= state_d;
      read_mode_o <= mode_d;
      op_valid_o  <= fire_d;
      if (fire_d) begin
        op_code_o <= code_d;
        op_addr_o <= addr_i;
        op_data_o <= data_i;
      end
    end
  end

  p_pulse_from_write_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |-> $past(wr_i));

  p_lockout_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockout_i |=> (!op_valid_o && read_mode_o == RM_ARRAY));

  p_prog_busy_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && prog_busy_i && !lockout_i) |=> (!op_valid_o && $stable(read_mode_o)));

  p_erase_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && erase_busy_i && !prog_busy_i && !lockout_i) |=>
      (!op_valid_o || op_code_o == OP_READ || op_code_o == OP_SUSP));

  p_susp_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && erase_susp_i && !erase_busy_i && !prog_busy_i && !lockout_i) |=>
      (!op_valid_o || op_code_o == OP_PROG || op_code_o == OP_RESUME));

  p_prog_status_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && op_code_o == OP_PROG) |-> read_mode_o == RM_STATUS);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8,
  parameter int CMP_W  = 12,
  parameter logic [CMP_W-1:0] KEY1_A = 12'h555,
  parameter logic [CMP_W-1:0] KEY2_A = 12'hAAA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lockout_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              erase_busy_i,
  input  logic              erase_susp_i,
  input  logic              prog_busy_i,
  output logic              op_valid_o,
  output logic [2:0]        op_code_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic [1:0]        read_mode_o
);
  logic   key1, key2, at_cmd;
  op_e    code;
  rmode_e mode;

  flash_wr_classify #(
    .CMP_W(CMP_W), .DATA_W(DATA_W), .KEY1_A(KEY1_A), .KEY2_A(KEY2_A)
  ) u_cls (
    .addr_lo_i(addr_i[CMP_W-1:0]),
    .data_i   (data_i),
    .key1_o   (key1),
    .key2_o   (key2),
    .at_cmd_o (at_cmd)
  );

  flash_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lockout_i   (lockout_i),
    .wr_i        (wr_i),
    .addr_i      (addr_i),
    .data_i      (data_i),
    .key1_i      (key1),
    .key2_i      (key2),
    .at_cmd_i    (at_cmd),
    .erase_busy_i(erase_busy_i),
    .erase_susp_i(erase_susp_i),
    .prog_busy_i (prog_busy_i),
    .op_valid_o  (op_valid_o),
    .op_code_o   (code),
    .op_addr_o   (op_addr_o),
    .op_data_o   (op_data_o),
    .read_mode_o (mode)
  );

  assign op_code_o   = code;
  assign read_mode_o = mode;
endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb_top;
  typedef struct packed {
    logic        eb;
    logic        es;
    logic        pb;
    logic [17:0] a;
    logic [7:0]  d;
    logic        v;
    logic [2:0]  c;
    logic [1:0]  m;
    logic [3:0]  r;
  } vec_t;

  localparam int NV = 50;
  localparam vec_t VEC [NV] = '{
    '{0,0,0,18'h00555,8'hAA,0,3'd0,2'd0,4'd1},
    '{0,0,0,18'h00AAA,8'h55,0,3'd0,2'd0,4'd1},
    '{0,0,0,18'h00555,8'h90,1,3'd1,2'd1,4'd2},
    '{0,0,0,18'h00000,8'hF0,1,3'd0,2'd0,4'd6},
    '{0,0,0,18'h00555,8'hAA,0,3'd0,2'd0,4'd3},
    '{0,0,0,18'h00AAA,8'h55,0,3'd0,2'd0,4'd3},
    '{0,0,0,18'h00555,8'hA0,0,3'd0,2'd0,4'd3},
    '{0,0,0,18'h31234,8'h12,1,3'd2,2'd2,4'd3},
    '{0,0,0,18'h00555,8'hAA,0,3'd0,2'd2,4'd4},
    '{0,0,0,18'h00AAA,8'h55,0,3'd0,2'd2,4'd4},
    '{0,0,0,18'h00555,8'h80,0,3'd0,2'd2,4'd4},
    '{0,0,0,18'h00555,8'hAA,0,3'd0,2'd2,4'd4},
    '{0,0,0,18'h00AAA,8'h55,0,3'd0,2'd2,4'd4},
    '{0,0,0,18'h20000,8'h30,1,3'd3,2'd2,4'd4},
    '{1,0,0,18'h00555,8'hAA,0,3'd0,2'd2,4'd7},
    '{1,0,0,18'h00123,8'hB0,1,3'd5,2'd0,4'd7},
    '{0,1,0,18'h00007,8'h30,1,3'd6,2'd2,4'd8},
    '{0,1,0,18'h00555,8'hAA,0,3'd0,2'd2,4'd8},
    '{0,1,0,18'h00AAA,8'h55,0,3'd0,2'd2,4'd8},
    '{0,1,0,18'h00555,8'hA0,0,3'd0,2'd2,4'd8},
    '{0,1,0,18'h00100,8'h55,1,3'd2,2'd2,4'd8},
    '{0,0,0,18'h00555,8'hAA,0,3'd0,2'd2,4'd5},
    '{0,0,0,18'h00AAA,8'h55,0,3'd0,2'd2,4'd5},
    '{0,0,0,18'h00555,8'h80,0,3'd0,2'd2,4'd5},
    '{0,0,0,18'h00555,8'hAA,0,3'd0,2'd2,4'd5},
    '{0,0,0,18'h00AAA,8'h55,0,3'd0,2'd2,4'd5},
    '{0,0,0,18'h00555,8'h10,1,3'd4,2'd2,4'd5},
    '{0,0,0,18'h00555,8'hAA,0,3'd0,2'd2,4'd9},
    '{0,0,0,18'h00AAA,8'h77,0,3'd0,2'd0,4'd9},
    '{0,0,0,18'h00555,8'hA0,0,3'd0,2'd0,4'd9},
    '{0,0,0,18'h3F555,8'hAA,0,3'd0,2'd0,4'd1},
    '{0,0,0,18'h10AAA,8'h55,0,3'd0,2'd0,4'd1},
    '{0,0,0,18'h20555,8'h90,1,3'd1,2'd1,4'd1},
    '{0,0,0,18'h00555,8'hAA,0,3'd0,2'd1,4'd9},
    '{0,0,0,18'h00AAA,8'h55,0,3'd0,2'd1,4'd9},
    '{0,0,0,18'h00555,8'h80,0,3'd0,2'd1,4'd9},
    '{0,0,0,18'h00555,8'h12,0,3'd0,2'd0,4'd9},
    '{0,0,0,18'h00000,8'h30,0,3'd0,2'd0,4'd9},
    '{0,0,0,18'h00555,8'hAA,0,3'd0,2'd0,4'd6},
    '{0,0,0,18'h00AAA,8'h55,0,3'd0,2'd0,4'd6},
    '{0,0,0,18'h00ABC,8'hF0,1,3'd0,2'd0,4'd6},
    '{0,0,0,18'h00555,8'hAA,0,3'd0,2'd0,4'd11},
    '{0,0,0,18'h00AAA,8'h55,0,3'd0,2'd0,4'd11},
    '{0,0,1,18'h00555,8'h90,0,3'd0,2'd0,4'd11},
    '{0,0,0,18'h00555,8'h90,1,3'd1,2'd1,4'd11},
    '{0,1,0,18'h00555,8'hAA,0,3'd0,2'd1,4'd8},
    '{0,1,0,18'h00AAA,8'h55,0,3'd0,2'd1,4'd8},
    '{0,1,0,18'h00555,8'h90,0,3'd0,2'd0,4'd8},
    '{1,0,0,18'h00000,8'hF0,1,3'd0,2'd0,4'd7},
    '{0,0,0,18'h00000,8'hB0,0,3'd0,2'd0,4'd9}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lockout = 1'b0;
  logic        wr = 1'b0;
  logic [17:0] addr = '0;
  logic [7:0]  data = '0;
  logic        eb = 1'b0, es = 1'b0, pb = 1'b0;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [17:0] op_addr;
  logic [7:0]  op_data;
  logic [1:0]  rmode;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flash_cmd_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .lockout_i(lockout), .wr_i(wr),
    .addr_i(addr), .data_i(data), .erase_busy_i(eb), .erase_susp_i(es),
    .prog_busy_i(pb), .op_valid_o(op_valid), .op_code_o(op_code),
    .op_addr_o(op_addr), .op_data_o(op_data), .read_mode_o(rmode)
  );

  function automatic string rname(input logic [3:0] r);
    case (r)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; 4'd11: return "R11"; default: return "R12";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic write1(input logic e_b, input logic e_s, input logic p_b,
                        input logic [17:0] a, input logic [7:0] d, input logic lk);
    @(negedge clk);
    eb = e_b; es = e_s; pb = p_b; addr = a; data = d; wr = 1'b1; lockout = lk;
    @(negedge clk);
    wr = 1'b0; lockout = 1'b0; eb = 1'b0; es = 1'b0; pb = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "reset valid", {31'd0, op_valid}, 32'd0);
    chk("R10", "reset mode", {30'd0, rmode}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      write1(VEC[i].eb, VEC[i].es, VEC[i].pb, VEC[i].a, VEC[i].d, 1'b0);
      chk(rname(VEC[i].r), $sformatf("vec %0d pulse", i),
          {28'd0, op_valid, op_valid ? op_code : 3'd0}, {28'd0, VEC[i].v, VEC[i].c});
      chk(rname(VEC[i].r), $sformatf("vec %0d mode", i), {30'd0, rmode}, {30'd0, VEC[i].m});
      if (VEC[i].v && (VEC[i].c == 3'd2 || VEC[i].c == 3'd3)) begin
        chk(rname(VEC[i].r), $sformatf("vec %0d addr", i), {14'd0, op_addr}, {14'd0, VEC[i].a});
        chk(rname(VEC[i].r), $sformatf("vec %0d data", i), {24'd0, op_data}, {24'd0, VEC[i].d});
      end
    end

    // R12: pulse lasts one cycle
    write1(0, 0, 0, 18'h0, 8'hF0, 1'b0);
    @(negedge clk);
    chk("R12", "pulse width", {31'd0, op_valid}, 32'd0);

    // R10: lockout mid-sequence clears key progress and autoselect mode
    write1(0, 0, 0, 18'h555, 8'hAA, 1'b0);
    write1(0, 0, 0, 18'hAAA, 8'h55, 1'b0);
    write1(0, 0, 0, 18'h555, 8'h90, 1'b0);
    chk("R2", "autoselect before lockout", {30'd0, rmode}, 32'd1);
    write1(0, 0, 0, 18'h555, 8'hAA, 1'b0);
    write1(0, 0, 0, 18'hAAA, 8'h55, 1'b1);
    chk("R10", "lockout no pulse", {31'd0, op_valid}, 32'd0);
    chk("R10", "lockout mode", {30'd0, rmode}, 32'd0);
    write1(0, 0, 0, 18'h555, 8'hA0, 1'b0);
    write1(0, 0, 0, 18'h00042, 8'h00, 1'b0);
    chk("R10", "sequence cleared by lockout", {31'd0, op_valid}, 32'd0);

    // R10: async reset mid-sequence
    write1(0, 0, 0, 18'h555, 8'hAA, 1'b0);
    write1(0, 0, 0, 18'hAAA, 8'h55, 1'b0);
    @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    write1(0, 0, 0, 18'h555, 8'h90, 1'b0);
    chk("R10", "reset cleared sequence", {31'd0, op_valid}, 32'd0);
    chk("R9", "stray 90h gives array", {30'd0, rmode}, 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R12 watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule